// File: doc/BRIEF.md
# Two-Context Coarse-Grained Thread Switch Controller

This block chooses which of two hardware thread contexts feeds a short in-order pipeline. It holds a program counter for each context and presents the fetch address of the running context, together with that context's ID. The pipeline uses the ID to pick the matching register file. One context is fixed at build time as the favoured one. It keeps the pipeline until it suffers a last-level cache miss. The other context then runs until the favoured one's miss has been serviced, and control goes back at once.

The pipeline is not split between contexts. Each change of context raises a one-cycle flush that discards everything in flight. Fetch of the newly selected context starts on the cycle after that flush. A missing instruction's address comes in with its miss pulse and is kept as that context's restart address, so the instruction runs again when the context resumes. If both contexts are blocked on misses, fetch stops until one returns. Short-latency events such as first-level misses never reach this block, so they cannot force a change of context.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters its reset state, which appears after that edge: `act_tid` equals the favoured ID (default 0), `fetch_pc` equals that context's reset address (default 0x100 for ID 0, 0x800 for ID 1), `flush` is 0, `fetch_vld` is 1, and no context is blocked.
- R2: When `fetch_vld` and `fetch_rdy` are both high at an edge, the running context's PC grows by `PC_STEP` (default 4) after that edge. If `fetch_rdy` is low, the PC holds.
- R3: A miss pulse (`miss_vld[i]` high, bit i belonging to context i) from the favoured context while it runs makes `act_tid` name the other context and `flush` high, both in the cycle after the edge. `fetch_vld` is low in that cycle and high in the one after it, with `fetch_pc` at the other context's kept PC.
- R4: The restart address of a context that has missed is the `miss_pc` sampled with its miss. When that context next fetches, `fetch_pc` starts there.
- R5: A return pulse (`ret_vld[i]`) for the blocked favoured context switches back to it with a one-cycle flush, even while the other context is running.
- R6: A miss pulse for a context that is not running, or for a running context that is already blocked, is ignored. There is no flush, no change of ID, and that context's PC is unchanged.
- R7: A return pulse for a context that is not blocked is ignored.
- R8: When the running context misses while the other is blocked, `flush` pulses and `fetch_vld` then stays low until a return arrives. A return for the context that is still selected resumes its fetch with no flush.
- R9: If both contexts are blocked and both return in the same cycle, the favoured context is selected.
- R10: Whenever the favoured context is not blocked, it is the running context.
- R11: Every change of `act_tid` is accompanied by `flush` high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_vld | input | 2 | Last-level miss pulse, one bit per context |
| miss_pc | input | PC_W | Address of the missing instruction, sampled with a miss |
| ret_vld | input | 2 | Miss-serviced pulse, one bit per context |
| fetch_rdy | input | 1 | Fetch stage accepts the presented address |
| act_tid | output | 1 | ID of the running context (register file select) |
| fetch_vld | output | 1 | `fetch_pc` is valid for fetch |
| fetch_pc | output | PC_W | Fetch address of the running context |
| flush | output | 1 | One-cycle pipeline flush on a change of context |

## Verification
The assertions assume that every miss pulse carries the address of the instruction that missed, and that a return pulse only follows a miss from the same context. Under those assumptions a context's PC moves only while it runs, and a blocked flag rises only for the running context. The stimulus keeps to these assumptions on the normal path. It only breaks them to exercise the ignored-pulse cases of R6 and R7, and the design drops those pulses, so the assumptions still hold for the state it keeps. Random pulse timing is not used. Every miss and return sits on a chosen cycle, so the switch, idle and simultaneous-return orderings each occur at least once.

// File: rtl/cgmt_pkg.sv
// Shared types for the coarse-grained thread switch controller.
// Assumes exactly two hardware contexts, so an ID is one bit.
package cgmt_pkg;
    localparam int unsigned NUM_THR = 2;
    localparam int unsigned TID_W   = 1;
    typedef logic [TID_W-1:0] tid_t;
endpackage

// File: rtl/cgmt_pc_bank.sv
// Per-context program counters. Only the running context's PC changes.
// A miss load has priority over a fetch advance.
// Assumes load is only raised for the running context.
module cgmt_pc_bank
    import cgmt_pkg::*;
#(
    parameter int unsigned     PC_W    = 32,
    parameter int unsigned     PC_STEP = 4,
    parameter logic [PC_W-1:0] RST_PC0 = 32'h100,
    parameter logic [PC_W-1:0] RST_PC1 = 32'h800
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  tid_t                         run_tid,
    input  logic                         adv,
    input  logic                         load,
    input  logic [PC_W-1:0]              load_pc,
    output logic [NUM_THR-1:0][PC_W-1:0] pc_q
);
    localparam logic [PC_W-1:0] STEP_V = PC_STEP[PC_W-1:0];

    logic past_vld;

    // Marks that at least one clock has passed since reset, for $past checks.
    always_ff @(posedge clk) begin
        if (!rst_n) past_vld <= 1'b0;
        else        past_vld <= 1'b1;
    end

    for (genvar i = 0; i < NUM_THR; i++) begin : g_ctx
        localparam logic [PC_W-1:0] RST_V = (i == 0) ? RST_PC0 : RST_PC1;

        // Keeps context i's PC: reset, reload on miss, or step on fetch.
        always_ff @(posedge clk) begin
            if (!rst_n)                                pc_q[i] <= RST_V;
            else if (run_tid == tid_t'(i) && load)     pc_q[i] <= load_pc;
            else if (run_tid == tid_t'(i) && adv)      pc_q[i] <= pc_q[i] + STEP_V;
        end

        // R6
        pc_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_vld && $past(run_tid) != tid_t'(i)) |-> $stable(pc_q[i]));
    end
endmodule

// File: rtl/cgmt_wait_trk.sv
// Blocked-on-miss flags. A miss counts only for the running, unblocked
// context. A return clears a flag only when it is set.
// Assumes pulses are one cycle wide per event.
module cgmt_wait_trk
    import cgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  tid_t               run_tid,
    input  logic [NUM_THR-1:0] miss_vld,
    input  logic [NUM_THR-1:0] ret_vld,
    output logic               acc_miss,
    output logic [NUM_THR-1:0] wait_q,
    output logic [NUM_THR-1:0] wait_nxt
);
    logic past_vld;

    // Decides whether the running context's miss is taken.
    always_comb begin
        acc_miss = miss_vld[run_tid] && !wait_q[run_tid];
    end

    // Builds the next blocked flags from accepted misses and returns.
    always_comb begin
        for (int i = 0; i < NUM_THR; i++) begin
            wait_nxt[i] = (wait_q[i] && !ret_vld[i]) ||
                          (acc_miss && run_tid == tid_t'(i));
        end
    end

    // Holds the blocked flags.
    always_ff @(posedge clk) begin
        if (!rst_n) wait_q <= '0;
        else        wait_q <= wait_nxt;
    end

    // Marks that at least one clock has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_vld <= 1'b0;
        else        past_vld <= 1'b1;
    end

    for (genvar i = 0; i < NUM_THR; i++) begin : g_chk
        // R6
        wait_only_runner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_vld && $rose(wait_q[i])) |-> ($past(run_tid) == tid_t'(i)));
    end
endmodule

// File: rtl/cgmt_thr_pick.sv
// Chooses the running context from the next blocked flags. The favoured
// context wins whenever it is free. With both blocked, the choice holds.
// Raises a one-cycle flush on an accepted miss or any change of context.
module cgmt_thr_pick
    import cgmt_pkg::*;
#(
    parameter int unsigned PREF = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_THR-1:0] wait_nxt,
    input  logic               acc_miss,
    output tid_t               run_tid,
    output logic               flush_q
);
    localparam tid_t PREF_T = tid_t'(PREF);
    localparam tid_t OTH_T  = tid_t'(1 - PREF);

    tid_t tid_nxt;
    logic flush_nxt;

    // Priority pick: favoured, then other, else keep the current one.
    always_comb begin
        if (!wait_nxt[PREF_T])     tid_nxt = PREF_T;
        else if (!wait_nxt[OTH_T]) tid_nxt = OTH_T;
        else                       tid_nxt = run_tid;
        flush_nxt = acc_miss || (tid_nxt != run_tid);
    end

    // Registers the selected context and the flush pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_tid <= PREF_T;
            flush_q <= 1'b0;
        end else begin
            run_tid <= tid_nxt;
            flush_q <= flush_nxt;
        end
    end
endmodule

// File: rtl/cgmt_switch_ctrl.sv
// Top of the coarse-grained thread switch controller for two contexts.
// Tracks blocked flags, picks the context and keeps per-context PCs.
// Fetch is gated in the flush cycle and while the selected context is blocked.
// Assumes miss_pc is the address of the missing instruction.
module cgmt_switch_ctrl
    import cgmt_pkg::*;
#(
    parameter int unsigned     PC_W    = 32,
    parameter int unsigned     PC_STEP = 4,
    parameter int unsigned     PREF    = 0,
    parameter logic [PC_W-1:0] RST_PC0 = 32'h100,
    parameter logic [PC_W-1:0] RST_PC1 = 32'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        miss_vld,
    input  logic [PC_W-1:0]   miss_pc,
    input  logic [1:0]        ret_vld,
    input  logic              fetch_rdy,
    output logic              act_tid,
    output logic              fetch_vld,
    output logic [PC_W-1:0]   fetch_pc,
    output logic              flush
);
    tid_t                         run_tid;
    logic                         flush_q;
    logic                         acc_miss;
    logic [NUM_THR-1:0]           wait_q;
    logic [NUM_THR-1:0]           wait_nxt;
    logic [NUM_THR-1:0][PC_W-1:0] pc_q;
    logic                         fire;
    logic                         past_vld;

    cgmt_wait_trk u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_tid  (run_tid),
        .miss_vld (miss_vld),
        .ret_vld  (ret_vld),
        .acc_miss (acc_miss),
        .wait_q   (wait_q),
        .wait_nxt (wait_nxt)
    );

    cgmt_thr_pick #(.PREF(PREF)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_nxt (wait_nxt),
        .acc_miss (acc_miss),
        .run_tid  (run_tid),
        .flush_q  (flush_q)
    );

    cgmt_pc_bank #(
        .PC_W    (PC_W),
        .PC_STEP (PC_STEP),
        .RST_PC0 (RST_PC0),
        .RST_PC1 (RST_PC1)
    ) u_pcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_tid (run_tid),
        .adv     (fire),
        .load    (acc_miss),
        .load_pc (miss_pc),
        .pc_q    (pc_q)
    );

    // Drives the fetch interface from the selected context.
    always_comb begin
        fetch_vld = !flush_q && !wait_q[run_tid];
        fire      = fetch_vld && fetch_rdy;
        fetch_pc  = pc_q[run_tid];
        act_tid   = run_tid;
        flush     = flush_q;
    end

    // Marks that at least one clock has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_vld <= 1'b0;
        else        past_vld <= 1'b1;
    end

    // R10
    pref_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_q[tid_t'(PREF)] |-> (run_tid == tid_t'(PREF)));

    // R11
    switch_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_vld && act_tid != $past(act_tid)) |-> flush);
endmodule

// File: tb/cgmt_switch_ctrl_bench.sv
// Scoreboard bench: the driver computes the expected outputs for each edge and
// queues them; the monitor compares them shortly after that edge.
module cgmt_switch_ctrl_bench;
    localparam int unsigned PCW  = 32;
    localparam logic [31:0] STEP = 32'd4;

    typedef struct {
        logic        tid;
        logic        flush;
        logic        vld;
        logic [31:0] pc;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  miss_vld = '0;
    logic [31:0] miss_pc = '0;
    logic [1:0]  ret_vld = '0;
    logic        fetch_rdy = 1'b0;
    logic        act_tid;
    logic        fetch_vld;
    logic [31:0] fetch_pc;
    logic        flush;

    exp_t        sb_q[$];
    int          checks = 0;
    int          failures = 0;
    int          cyc_cnt = 0;

    logic        m_tid = 1'b0;
    logic        m_flush = 1'b0;
    logic [1:0]  m_wait = '0;
    logic [31:0] m_pc [2] = '{32'h100, 32'h800};

    always #4 clk = ~clk;

    cgmt_switch_ctrl u_cgmt_switch_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss_vld  (miss_vld),
        .miss_pc   (miss_pc),
        .ret_vld   (ret_vld),
        .fetch_rdy (fetch_rdy),
        .act_tid   (act_tid),
        .fetch_vld (fetch_vld),
        .fetch_pc  (fetch_pc),
        .flush     (flush)
    );

    // Drives one cycle of inputs and queues the outputs expected after the edge.
    task automatic cyc(input logic rn, input logic [1:0] mv, input logic [31:0] mp,
                       input logic [1:0] rv, input logic rdy, input string tag);
        exp_t        e;
        logic        v;
        logic        acc;
        logic [1:0]  w;
        logic        nt;
        @(negedge clk);
        rst_n = rn; miss_vld = mv; miss_pc = mp; ret_vld = rv; fetch_rdy = rdy;
        if (!rn) begin
            m_tid = 1'b0; m_flush = 1'b0; m_wait = '0;
            m_pc[0] = 32'h100; m_pc[1] = 32'h800;
        end else begin
            v   = !m_flush && !m_wait[m_tid];
            acc = mv[m_tid] && !m_wait[m_tid];
            if (acc)           m_pc[m_tid] = mp;
            else if (v && rdy) m_pc[m_tid] = m_pc[m_tid] + STEP;
            w = m_wait;
            for (int i = 0; i < 2; i++) if (rv[i] && m_wait[i]) w[i] = 1'b0;
            if (acc) w[m_tid] = 1'b1;
            if (!w[0])      nt = 1'b0;
            else if (!w[1]) nt = 1'b1;
            else            nt = m_tid;
            m_flush = acc || (nt != m_tid);
            m_tid   = nt;
            m_wait  = w;
        end
        e.tid = m_tid; e.flush = m_flush; e.vld = !m_flush && !m_wait[m_tid];
        e.pc = m_pc[m_tid]; e.req = tag;
        sb_q.push_back(e);
    endtask

    task automatic step(input logic [1:0] mv, input logic [31:0] mp,
                        input logic [1:0] rv, input logic rdy, input string tag);
        cyc(1'b1, mv, mp, rv, rdy, tag);
    endtask

    // Monitor: compares the design's outputs with the queued expectation.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++;
            if (act_tid !== e.tid || flush !== e.flush || fetch_vld !== e.vld ||
                (e.vld && fetch_pc !== e.pc)) begin
                failures++;
                $display("FAIL %s: tid=%0d flush=%0d vld=%0d pc=%h expected tid=%0d flush=%0d vld=%0d pc=%h",
                         e.req, act_tid, flush, fetch_vld, fetch_pc,
                         e.tid, e.flush, e.vld, e.pc);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 5000) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected below 5000", cyc_cnt);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc(1'b0, 2'b00, 32'h0, 2'b00, 1'b1, "R1");
        cyc(1'b0, 2'b00, 32'h0, 2'b00, 1'b1, "R1");
        // R2: advance with ready, hold without
        for (int k = 0; k < 4; k++) step(2'b00, 32'h0, 2'b00, 1'b1, "R2");
        for (int k = 0; k < 2; k++) step(2'b00, 32'h0, 2'b00, 1'b0, "R2");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R2");
        // R6: miss from the idle context ignored
        step(2'b10, 32'h0BAD, 2'b00, 1'b1, "R6");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R6");
        // R7: return for an unblocked context ignored
        step(2'b00, 32'h0, 2'b11, 1'b1, "R7");
        // R3: favoured miss switches with flush
        step(2'b01, 32'h120, 2'b00, 1'b1, "R3");
        for (int k = 0; k < 3; k++) step(2'b00, 32'h0, 2'b00, 1'b1, "R3");
        // R6, R7: pulses for the blocked or idle context while the other runs
        step(2'b01, 32'h0BAD, 2'b10, 1'b1, "R6");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R7");
        // R5, R4: return switches back and restarts at the missing address
        step(2'b00, 32'h0, 2'b01, 1'b1, "R5");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R4");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R4");
        // R8: both blocked, gate fetch, then resume the other without flush
        step(2'b01, 32'h140, 2'b00, 1'b1, "R3");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R3");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R3");
        step(2'b10, 32'h900, 2'b00, 1'b1, "R8");
        for (int k = 0; k < 3; k++) step(2'b00, 32'h0, 2'b00, 1'b1, "R8");
        step(2'b00, 32'h0, 2'b10, 1'b1, "R8");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R8");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R8");
        step(2'b00, 32'h0, 2'b01, 1'b1, "R11");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R10");
        // R9: simultaneous returns, favoured wins
        step(2'b01, 32'h200, 2'b00, 1'b1, "R3");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R3");
        step(2'b10, 32'hA00, 2'b00, 1'b1, "R8");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R8");
        step(2'b00, 32'h0, 2'b11, 1'b1, "R9");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R9");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R4");
        // R4: other context restarts at its kept miss address
        step(2'b01, 32'h300, 2'b00, 1'b1, "R4");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R4");
        step(2'b00, 32'h0, 2'b00, 1'b0, "R4");
        // R1: reset mid-run
        cyc(1'b0, 2'b00, 32'h0, 2'b00, 1'b1, "R1");
        step(2'b00, 32'h0, 2'b00, 1'b1, "R1");
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule